// File: doc/BRIEF.md
# Halfword Logical and Compare Unit

This block is the execution stage for the logical class of a 16-bit minicomputer. Each cycle it can accept one operation: an 8-bit opcode, the current value of the destination register as the first operand, and a second operand that earlier stages have already resolved. That second operand may come from a register, from memory, or from an immediate sum. The unit does not care which. It computes bitwise AND, inclusive OR or exclusive OR and sends the result back toward the destination register. It can also run a compare, which changes no operand. Every legal operation produces a four-bit condition code made of carry (C), overflow (V), greater (G) and less (L).

Each function has three opcode encodings: register form, memory form and immediate form. All three decode to the same operation. The unit registers its outputs, so results show up exactly one clock after the input strobe, together with a one-cycle output valid pulse. Any opcode outside the twelve legal ones raises an illegal-opcode flag instead of producing a result.

Top module: `hwlc_unit`

## Requirements
- R1: Opcodes 0x04, 0x44 and 0xC4 perform AND. The result is opa AND opb, and wr_en is 1.
- R2: Opcodes 0x06, 0x46 and 0xC6 perform OR. Opcodes 0x07, 0x47 and 0xC7 perform exclusive OR. Each gives the bitwise result with wr_en at 1.
- R3: Opcodes 0x05, 0x45 and 0xC5 perform compare. wr_en stays 0 and result carries opa unchanged.
- R4: The cc port is {C,V,G,L}, with C at bit 3 and L at bit 0. For AND, OR and exclusive OR, C and V are 0. A zero result gives 4'b0000. A result whose most significant bit (bit 15) is 1 gives L only (4'b0001). Any other nonzero result gives G only (4'b0010).
- R5: Compare uses the unsigned order. Equal operands give 4'b0000. When opa is less than opb the code is C=1, L=1 (4'b1001). When opa is greater the code is G only (4'b0010). V is always 0.
- R6: Any other opcode, including 0x84, 0x00 and 0x0C, sets illegal to 1. In that case cc is 4'b0000, result is 0 and wr_en is 0.
- R7: out_valid, wr_en and illegal are driven one clock after an in_valid strobe and last for one cycle per strobe. Strobes may arrive back to back. A cycle without in_valid leaves result and cc unchanged, and the next cycle has out_valid, wr_en and illegal all at 0.
- R8: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 8 | Operation code |
| opa | input | 16 | First operand (destination register value) |
| opb | input | 16 | Resolved second operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 16 | Value for the destination register |
| wr_en | output | 1 | Destination write enable |
| cc | output | 4 | Condition code {C,V,G,L} |
| illegal | output | 1 | Opcode not in the logical class |

## Verification
The hardest case to reach is a compare whose carry and less bits depend on the unsigned order while the signed order points the other way. One example is 0x8000 against 0x7FFF. Another is 0x0000 against 0xFFFF. The vector table contains these pairs on purpose, along with results that have only the top bit set, so the G and L split is exercised at its boundary. Illegal opcodes are placed between legal ones so that the decoder has to reject encodings that differ from a valid opcode only in the form bits (0x84) or only in the function bits (0x0C).

// File: rtl/hwlc_pkg.sv
package hwlc_pkg;
  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_CMP = 2'b01,
    FN_OR  = 2'b10,
    FN_XOR = 2'b11
  } fn_e;

  typedef struct packed {
    logic c;
    logic v;
    logic g;
    logic l;
  } cc_t;

  localparam cc_t CC_NONE = '{c: 1'b0, v: 1'b0, g: 1'b0, l: 1'b0};
endpackage

// File: rtl/hwlc_decode.sv
module hwlc_decode
  import hwlc_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0] opcode,
  output fn_e            fn,
  output logic           legal
);
  localparam int FORM_LSB = OPW - 2;

  logic [1:0]        form;
  logic [FORM_LSB-1:0] body;
  logic form_ok;
  logic body_ok;

  assign form = opcode[OPW-1:FORM_LSB];
  assign body = opcode[FORM_LSB-1:0];

  // Register, memory and immediate forms are 00, 01 and 11 in the top two bits.
  always_comb begin
    case (form)
      2'b00, 2'b01, 2'b11: form_ok = 1'b1;
      default:             form_ok = 1'b0;
    endcase
  end

  // The remaining bits must select function 4..7.
  assign body_ok = (body[FORM_LSB-1:2] == 1);
  assign legal   = form_ok && body_ok;
  assign fn      = fn_e'(body[1:0]);
endmodule

// File: rtl/hwlc_logic.sv
module hwlc_logic
  import hwlc_pkg::*;
#(
  parameter int W = 16
) (
  input  fn_e          fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output cc_t          cc
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (fn)
        FN_AND:  res[i] = a[i] & b[i];
        FN_OR:   res[i] = a[i] | b[i];
        FN_XOR:  res[i] = a[i] ^ b[i];
        default: res[i] = 1'b0;
      endcase
    end
  end

  logic nonzero;
  assign nonzero = |res;

  always_comb begin
    cc   = CC_NONE;
    cc.l = res[W-1];
    cc.g = nonzero && !res[W-1];
  end
endmodule

// File: rtl/hwlc_cmp.sv
module hwlc_cmp
  import hwlc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cc_t          cc
);
  logic [W:0] diff;
  logic       below;
  logic       same;

  // A borrow out of the widened subtraction marks a < b (unsigned).
  assign diff  = {1'b0, a} - {1'b0, b};
  assign below = diff[W];
  assign same  = (diff[W-1:0] == '0);

  always_comb begin
    cc   = CC_NONE;
    cc.c = below;
    cc.l = below;
    cc.g = !below && !same;
  end
endmodule

// File: rtl/hwlc_unit.sv
module hwlc_unit
  import hwlc_pkg::*;
#(
  parameter int W   = 16,
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] opcode,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic           out_valid,
  output logic [W-1:0]   result,
  output logic           wr_en,
  output logic [3:0]     cc,
  output logic           illegal
);
  fn_e          dec_fn;
  logic         dec_legal;
  logic [W-1:0] log_res;
  cc_t          log_cc;
  cc_t          cmp_cc;

  hwlc_decode #(.OPW(OPW)) u_dec (
    .opcode (opcode),
    .fn     (dec_fn),
    .legal  (dec_legal)
  );

  hwlc_logic #(.W(W)) u_log (
    .fn  (dec_fn),
    .a   (opa),
    .b   (opb),
    .res (log_res),
    .cc  (log_cc)
  );

  hwlc_cmp #(.W(W)) u_cmp (
    .a  (opa),
    .b  (opb),
    .cc (cmp_cc)
  );

  logic         vld_q, vld_d;
  logic         wr_q, wr_d;
  logic         ill_q, ill_d;
  logic [W-1:0] res_q, res_d;
  cc_t          cc_q, cc_d;
  logic         load_en;

  // result and cc are clock-enabled; the pulse outputs reload every cycle.
  assign load_en = in_valid;

  always_comb begin
    vld_d = in_valid;
    wr_d  = 1'b0;
    ill_d = 1'b0;
    res_d = res_q;
    cc_d  = cc_q;
    if (in_valid) begin
      if (!dec_legal) begin
        ill_d = 1'b1;
        res_d = '0;
        cc_d  = CC_NONE;
      end else if (dec_fn == FN_CMP) begin
        res_d = opa;
        cc_d  = cmp_cc;
      end else begin
        wr_d  = 1'b1;
        res_d = log_res;
        cc_d  = log_cc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wr_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      wr_q  <= wr_d;
      ill_q <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cc_q  <= CC_NONE;
    end else if (load_en) begin
      res_q <= res_d;
      cc_q  <= cc_d;
    end
  end

  assign out_valid = vld_q;
  assign wr_en     = wr_q;
  assign illegal   = ill_q;
  assign result    = res_q;
  assign cc        = cc_q;
endmodule

// File: rtl/hwlc_chk.sv
module hwlc_chk #(
  parameter int W   = 16,
  parameter int OPW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [OPW-1:0] opcode,
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic           out_valid,
  input logic [W-1:0]   result,
  input logic           wr_en,
  input logic [3:0]     cc,
  input logic           illegal
);
  logic is_and;
  logic is_cmp;
  assign is_and = (opcode == 8'h04) || (opcode == 8'h44) || (opcode == 8'hC4);
  assign is_cmp = (opcode == 8'h05) || (opcode == 8'h45) || (opcode == 8'hC5);

  p_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_and) |=> (wr_en && result == $past(opa & opb)));

  p_cmp_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp) |=> (!wr_en && result == $past(opa)));

  p_logic_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cc[3:2] == 2'b00 && cc[0] == result[W-1] &&
               (cc[1] | cc[0]) == (result != '0)));

  p_gl_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(cc[1] && cc[0]));

  p_cmp_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp) |=> (cc[2] == 1'b0 && cc[3] == cc[0] &&
      cc[0] == ($past(opa) < $past(opb)) && cc[1] == ($past(opa) > $past(opb))));

  p_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cc == 4'b0000 && !wr_en && result == '0 && out_valid));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !illegal && $stable(result) && $stable(cc)));
endmodule

bind hwlc_unit hwlc_chk #(.W(W), .OPW(OPW)) u_chk (.*);

// File: tb/sim_hwlc_unit.sv
module sim_hwlc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic        out_valid;
  logic [15:0] result;
  logic        wr_en;
  logic [3:0]  cc;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hwlc_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .cc(cc), .illegal(illegal)
  );

  // {req, opcode, opa, opb, exp_result, exp_wr, exp_cc, exp_illegal}
  localparam int NV = 18;
  localparam logic [65:0] VEC [NV] = '{
    {4'd1, 8'h04, 16'hA5A5, 16'h0FF0, 16'h05A0, 1'b1, 4'b0010, 1'b0}, // R1
    {4'd1, 8'h44, 16'hFFFF, 16'h8001, 16'h8001, 1'b1, 4'b0001, 1'b0}, // R1
    {4'd4, 8'hC4, 16'h1234, 16'hEDCB, 16'h0000, 1'b1, 4'b0000, 1'b0}, // R4 zero
    {4'd2, 8'h06, 16'h8000, 16'h0001, 16'h8001, 1'b1, 4'b0001, 1'b0}, // R2
    {4'd4, 8'h46, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'b0000, 1'b0}, // R4
    {4'd2, 8'hC6, 16'h0F00, 16'h00F0, 16'h0FF0, 1'b1, 4'b0010, 1'b0}, // R2
    {4'd2, 8'h07, 16'hAAAA, 16'h5555, 16'hFFFF, 1'b1, 4'b0001, 1'b0}, // R2
    {4'd2, 8'h47, 16'h1234, 16'h1234, 16'h0000, 1'b1, 4'b0000, 1'b0}, // R2
    {4'd4, 8'hC7, 16'h8000, 16'hC000, 16'h4000, 1'b1, 4'b0010, 1'b0}, // R4
    {4'd4, 8'h44, 16'h8000, 16'hFFFF, 16'h8000, 1'b1, 4'b0001, 1'b0}, // R4 top bit only
    {4'd5, 8'h05, 16'h0003, 16'h0007, 16'h0003, 1'b0, 4'b1001, 1'b0}, // R5 less
    {4'd5, 8'h45, 16'h8000, 16'h7FFF, 16'h8000, 1'b0, 4'b0010, 1'b0}, // R5 unsigned greater
    {4'd3, 8'hC5, 16'h5555, 16'h5555, 16'h5555, 1'b0, 4'b0000, 1'b0}, // R3 equal
    {4'd5, 8'hC5, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 4'b1001, 1'b0}, // R5 unsigned less
    {4'd6, 8'h84, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 4'b0000, 1'b1}, // R6 bad form
    {4'd6, 8'h00, 16'h1111, 16'h2222, 16'h0000, 1'b0, 4'b0000, 1'b1}, // R6
    {4'd6, 8'h0C, 16'h8000, 16'h8000, 16'h0000, 1'b0, 4'b0000, 1'b1}, // R6 bad function
    {4'd6, 8'hC8, 16'h0001, 16'h0001, 16'h0000, 1'b0, 4'b0000, 1'b1}  // R6
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] held_res;
    logic [3:0]  held_cc;
    // R8: reset state
    repeat (2) @(negedge clk);
    check("R8", "out_valid", {15'd0, out_valid}, 16'd0);
    check("R8", "result", result, 16'h0000);
    check("R8", "cc", {12'd0, cc}, 16'd0);
    check("R8", "wr_en/illegal", {14'd0, wr_en, illegal}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk, back-to-back strobes (R7)
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][65:62]);
      in_valid = 1'b1;
      opcode   = VEC[i][61:54];
      opa      = VEC[i][53:38];
      opb      = VEC[i][37:22];
      @(negedge clk);
      check("R7", "out_valid", {15'd0, out_valid}, 16'd1);
      check(rq, "result", result, VEC[i][21:6]);
      check(rq, "wr_en", {15'd0, wr_en}, {15'd0, VEC[i][5]});
      check(rq, "cc", {12'd0, cc}, {12'd0, VEC[i][4:1]});
      check(rq, "illegal", {15'd0, illegal}, {15'd0, VEC[i][0]});
    end

    // R7: idle cycles hold result and cc despite changing inputs
    in_valid = 1'b1; opcode = 8'h46; opa = 16'h0100; opb = 16'h0002;
    @(negedge clk);
    held_res = result;
    held_cc  = cc;
    check("R2", "result before idle", held_res, 16'h0102);
    in_valid = 1'b0; opcode = 8'h04; opa = 16'hFFFF; opb = 16'hFFFF;
    @(negedge clk);
    check("R7", "idle out_valid", {15'd0, out_valid}, 16'd0);
    check("R7", "idle wr_en", {15'd0, wr_en}, 16'd0);
    opcode = 8'h84;
    @(negedge clk);
    check("R7", "idle illegal", {15'd0, illegal}, 16'd0);
    check("R7", "held result", result, held_res);
    check("R7", "held cc", {12'd0, cc}, {12'd0, held_cc});

    // R3: compare after a write leaves result at opa, no write
    in_valid = 1'b1; opcode = 8'h45; opa = 16'h7FFF; opb = 16'h8000;
    @(negedge clk);
    check("R3", "cmp result", result, 16'h7FFF);
    check("R3", "cmp wr_en", {15'd0, wr_en}, 16'd0);
    check("R5", "cmp cc", {12'd0, cc}, 16'h0009);
    in_valid = 1'b0;
    @(negedge clk);

    // R8: reset mid-run clears outputs
    in_valid = 1'b1; opcode = 8'h07; opa = 16'hF0F0; opb = 16'h0000;
    @(negedge clk);
    check("R2", "xor before reset", result, 16'hF0F0);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8", "result in reset", result, 16'h0000);
    check("R8", "cc in reset", {12'd0, cc}, 16'd0);
    check("R8", "out_valid in reset", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule